// File: doc/BRIEF.md
# Speculative OR-Based Address Generator

This block forms a memory address from a base register value and a sign-extended immediate in two ways at once. The exact address comes from an ordinary 32-bit adder. Alongside it, a speculative address is formed in which the bits above the 5-bit line offset come from a single level of OR gates instead of an adder. A cache can therefore start indexing with the speculative bits before the adder has resolved.

A verify flag tells the consumer whether the speculative upper bits are correct. Speculation is declared good only when no carry could have reached those bits: the two line-offset fields must add without a carry into bit 5, and no upper bit position may be set in both operands. The low five bits of the speculative address are taken from the exact sum, since they only steer word selection later. The outputs are either combinational or registered once, selected by a parameter. The default is registered.

Top module: `spec_agu`

## Requirements
- R1: `true_addr_o` equals `base_i + imm_i` modulo 2^32.
- R2: Bits [31:5] of `spec_addr_o` equal the bitwise OR of bits [31:5] of `base_i` and of `imm_i`.
- R3: Bits [4:0] of `spec_addr_o` equal bits [4:0] of `true_addr_o`.
- R4: When `base_i[4:0] + imm_i[4:0]` carries into bit 5, `spec_ok_o` is 0.
- R5: When any bit in [31:5] is 1 in both `base_i` and `imm_i`, `spec_ok_o` is 0.
- R6: When there is neither a line-offset carry nor an upper overlap, `spec_ok_o` is 1. Whenever `spec_ok_o` is 1, `spec_addr_o` equals `true_addr_o`.
- R7: When `imm_i[31:5]` is all zero, `spec_addr_o[31:5]` equals `base_i[31:5]`, and `spec_ok_o` is 1 exactly when there is no line-offset carry.
- R8: When the immediate is negative (upper bits all ones), `spec_ok_o` is 0 unless `base_i[31:5]` is all zero and there is no line-offset carry.
- R9: With the default registered mode, all three outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low they are 0, and `spec_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| base_i | input | 32 | Base register value |
| imm_i | input | 32 | Sign-extended immediate |
| spec_addr_o | output | 32 | Speculative address: OR-formed upper field, exact low field |
| true_addr_o | output | 32 | Exact sum of base and immediate |
| spec_ok_o | output | 1 | 1 when the speculative upper field is guaranteed correct |

## Verification
The bench targets the carry boundary in the line offset. A line-offset sum of exactly 31 must pass, and a sum of 32 must fail; a design that compared against the wrong bit would flag a carried access as good and index the wrong line.

It also targets upper-field overlap and negative immediates. A design that dropped the overlap check would report success while its OR-formed bits differ from the sum. The case of a zero base upper field with a negative immediate must pass, while a non-zero base with the same immediate must fail.

The bench also covers all-ones operands, where the OR result happens to match the sum yet the flag must still be 0. A design that compared the two addresses instead of detecting carries would raise the flag there. A one-cycle latency check catches an output stage that is transparent or has extra stages.

// File: rtl/spec_agu_pkg.sv
package spec_agu_pkg;
    localparam int unsigned AGU_ADDR_W = 32;
    localparam int unsigned AGU_OFS_W  = 5;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;
endpackage

// File: rtl/spec_agu_lowfield.sv
module spec_agu_lowfield #(
    parameter int unsigned OFS_W = 5
) (
    input  logic [OFS_W-1:0] base_lo,
    input  logic [OFS_W-1:0] imm_lo,
    output logic [OFS_W-1:0] sum_lo,
    output logic             carry_up
);
    logic [OFS_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, base_lo} + {1'b0, imm_lo};
        sum_lo   = wide_sum[OFS_W-1:0];
        carry_up = wide_sum[OFS_W];
    end
endmodule

// File: rtl/spec_agu_upfield.sv
module spec_agu_upfield #(
    parameter int unsigned UP_W = 27
) (
    input  logic [UP_W-1:0] base_up,
    input  logic [UP_W-1:0] imm_up,
    input  logic            carry_in,
    output logic [UP_W-1:0] or_up,
    output logic [UP_W-1:0] sum_up,
    output logic            overlap
);
    logic [UP_W-1:0] both_set;

    for (genvar gi = 0; gi < UP_W; gi++) begin : g_bit
        assign or_up[gi]    = base_up[gi] | imm_up[gi];
        assign both_set[gi] = base_up[gi] & imm_up[gi];
    end

    assign overlap = |both_set;
    assign sum_up  = base_up + imm_up + {{(UP_W-1){1'b0}}, carry_in};
endmodule

// File: rtl/spec_agu_outstage.sv
module spec_agu_outstage #(
    parameter int unsigned            ADDR_W   = 32,
    parameter spec_agu_pkg::out_mode_e OUT_MODE = spec_agu_pkg::OUT_REG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] spec_d,
    input  logic [ADDR_W-1:0] sum_d,
    input  logic              ok_d,
    output logic [ADDR_W-1:0] spec_q,
    output logic [ADDR_W-1:0] sum_q,
    output logic              ok_q
);
    if (OUT_MODE == spec_agu_pkg::OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                spec_q <= '0;
                sum_q  <= '0;
                ok_q   <= 1'b0;
            end else begin
                spec_q <= spec_d;
                sum_q  <= sum_d;
                ok_q   <= ok_d;
            end
        end
    end else begin : g_comb
        always_comb begin
            spec_q = spec_d;
            sum_q  = sum_d;
            ok_q   = ok_d;
        end
    end
endmodule

// File: rtl/spec_agu.sv
module spec_agu #(
    parameter int unsigned             ADDR_W   = spec_agu_pkg::AGU_ADDR_W,
    parameter int unsigned             OFS_W    = spec_agu_pkg::AGU_OFS_W,
    parameter spec_agu_pkg::out_mode_e OUT_MODE = spec_agu_pkg::OUT_REG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] imm_i,
    output logic [ADDR_W-1:0] spec_addr_o,
    output logic [ADDR_W-1:0] true_addr_o,
    output logic              spec_ok_o
);
    localparam int unsigned UP_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0] sum_lo;
    logic             lo_carry;
    logic [UP_W-1:0]  or_up;
    logic [UP_W-1:0]  sum_up;
    logic             up_overlap;
    logic [ADDR_W-1:0] spec_d;
    logic [ADDR_W-1:0] sum_d;
    logic              ok_d;

    spec_agu_lowfield #(.OFS_W(OFS_W)) u_low (
        .base_lo  (base_i[OFS_W-1:0]),
        .imm_lo   (imm_i[OFS_W-1:0]),
        .sum_lo   (sum_lo),
        .carry_up (lo_carry)
    );

    spec_agu_upfield #(.UP_W(UP_W)) u_up (
        .base_up  (base_i[ADDR_W-1:OFS_W]),
        .imm_up   (imm_i[ADDR_W-1:OFS_W]),
        .carry_in (lo_carry),
        .or_up    (or_up),
        .sum_up   (sum_up),
        .overlap  (up_overlap)
    );

    always_comb begin
        spec_d = {or_up, sum_lo};
        sum_d  = {sum_up, sum_lo};
        ok_d   = ~lo_carry & ~up_overlap;
    end

    spec_agu_outstage #(.ADDR_W(ADDR_W), .OUT_MODE(OUT_MODE)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .spec_d (spec_d),
        .sum_d  (sum_d),
        .ok_d   (ok_d),
        .spec_q (spec_addr_o),
        .sum_q  (true_addr_o),
        .ok_q   (spec_ok_o)
    );
endmodule

// File: rtl/spec_agu_chk.sv
module spec_agu_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 5,
    parameter bit          REGD   = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] base_i,
    input logic [ADDR_W-1:0] imm_i,
    input logic [ADDR_W-1:0] spec_addr_o,
    input logic [ADDR_W-1:0] true_addr_o,
    input logic              spec_ok_o
);
    logic [ADDR_W-1:0] b_s;
    logic [ADDR_W-1:0] i_s;
    logic              vld;

    if (REGD) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_s <= '0;
                i_s <= '0;
                vld <= 1'b0;
            end else begin
                b_s <= base_i;
                i_s <= imm_i;
                vld <= 1'b1;
            end
        end
    end else begin : g_comb
        assign b_s = base_i;
        assign i_s = imm_i;
        assign vld = rst_n;
    end

    logic [OFS_W:0] lo_wide;
    logic           lo_cy;
    logic           ovl;
    assign lo_wide = {1'b0, b_s[OFS_W-1:0]} + {1'b0, i_s[OFS_W-1:0]};
    assign lo_cy   = lo_wide[OFS_W];
    assign ovl     = (b_s[ADDR_W-1:OFS_W] & i_s[ADDR_W-1:OFS_W]) != '0;

    AST_TRUE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> true_addr_o == b_s + i_s); // R1
    AST_SPEC_UPPER_OR: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> spec_addr_o[ADDR_W-1:OFS_W] == (b_s[ADDR_W-1:OFS_W] | i_s[ADDR_W-1:OFS_W])); // R2
    AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        spec_addr_o[OFS_W-1:0] == true_addr_o[OFS_W-1:0]); // R3
    AST_CARRY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && lo_cy) |-> !spec_ok_o); // R4
    AST_OVERLAP_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && ovl) |-> !spec_ok_o); // R5
    AST_OK_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        spec_ok_o |-> spec_addr_o == true_addr_o); // R6
    AST_CLEAN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !lo_cy && !ovl) |-> spec_ok_o); // R6
    AST_RESET_FLAG: assert property (@(posedge clk)
        !rst_n |-> !spec_ok_o); // R9
endmodule

bind spec_agu spec_agu_chk #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .REGD   (OUT_MODE == spec_agu_pkg::OUT_REG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_i      (base_i),
    .imm_i       (imm_i),
    .spec_addr_o (spec_addr_o),
    .true_addr_o (true_addr_o),
    .spec_ok_o   (spec_ok_o)
);

// File: tb/spec_agu_bench.sv
module spec_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [31:0] imm_i = '0;
    logic [31:0] spec_addr_o;
    logic [31:0] true_addr_o;
    logic        spec_ok_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    spec_agu u_spec_agu (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_i      (base_i),
        .imm_i       (imm_i),
        .spec_addr_o (spec_addr_o),
        .true_addr_o (true_addr_o),
        .spec_ok_o   (spec_ok_o)
    );

    task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] b, input logic [31:0] i);
        @(negedge clk);
        base_i = b;
        imm_i  = i;
        @(posedge clk);
        #1;
    endtask

    function automatic logic exp_ok(input logic [31:0] b, input logic [31:0] i);
        logic [5:0] lo;
        lo = {1'b0, b[4:0]} + {1'b0, i[4:0]};
        return !lo[5] && ((b[31:5] & i[31:5]) == 27'd0);
    endfunction

    task automatic full_check(input logic [31:0] b, input logic [31:0] i, input string ctx);
        logic [31:0] s;
        s = b + i;
        apply(b, i);
        chk(true_addr_o == s, {"R1 ", ctx}, true_addr_o, s);
        chk(spec_addr_o[31:5] == (b[31:5] | i[31:5]), {"R2 ", ctx}, spec_addr_o, {b[31:5] | i[31:5], 5'd0});
        chk(spec_addr_o[4:0] == s[4:0], {"R3 ", ctx}, spec_addr_o, s);
        chk(spec_ok_o == exp_ok(b, i), {"R6 flag ", ctx}, {31'd0, spec_ok_o}, {31'd0, exp_ok(b, i)});
        if (spec_ok_o)
            chk(spec_addr_o == s, {"R6 match ", ctx}, spec_addr_o, s);
    endtask

    task automatic t_reset;
        #1;
        chk(spec_addr_o == 32'd0, "R9 reset spec", spec_addr_o, 32'd0);
        chk(true_addr_o == 32'd0, "R9 reset sum", true_addr_o, 32'd0);
        chk(spec_ok_o == 1'b0, "R9 reset flag", {31'd0, spec_ok_o}, 32'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_small_imm;
        apply(32'h1000_0040, 32'h0000_0008);
        chk(spec_ok_o == 1'b1, "R7 small imm ok", {31'd0, spec_ok_o}, 32'd1);
        chk(spec_addr_o == 32'h1000_0048, "R7 small imm addr", spec_addr_o, 32'h1000_0048);
    endtask

    task automatic t_carry_edge;
        apply(32'h1000_0017, 32'h0000_0008);
        chk(spec_ok_o == 1'b1, "R4 sum 31 passes", {31'd0, spec_ok_o}, 32'd1);
        apply(32'h1000_0018, 32'h0000_0008);
        chk(spec_ok_o == 1'b0, "R4 sum 32 fails", {31'd0, spec_ok_o}, 32'd0);
        chk(spec_addr_o == 32'h1000_0000, "R7 upper from base", spec_addr_o, 32'h1000_0000);
        chk(true_addr_o == 32'h1000_0020, "R1 carry sum", true_addr_o, 32'h1000_0020);
    endtask

    task automatic t_overlap;
        apply(32'h0000_1000, 32'h0000_0200);
        chk(spec_ok_o == 1'b1, "R6 disjoint ok", {31'd0, spec_ok_o}, 32'd1);
        chk(spec_addr_o == 32'h0000_1200, "R2 disjoint addr", spec_addr_o, 32'h0000_1200);
        apply(32'h0000_1200, 32'h0000_0200);
        chk(spec_ok_o == 1'b0, "R5 overlap fails", {31'd0, spec_ok_o}, 32'd0);
        chk(spec_addr_o == 32'h0000_1200, "R2 overlap or", spec_addr_o, 32'h0000_1200);
    endtask

    task automatic t_negative;
        apply(32'h0000_0003, 32'hFFFF_FFFC);
        chk(spec_ok_o == 1'b1, "R8 zero base ok", {31'd0, spec_ok_o}, 32'd1);
        chk(spec_addr_o == 32'hFFFF_FFFF, "R8 zero base addr", spec_addr_o, 32'hFFFF_FFFF);
        apply(32'h2000_0003, 32'hFFFF_FFFC);
        chk(spec_ok_o == 1'b0, "R8 nonzero base fails", {31'd0, spec_ok_o}, 32'd0);
        apply(32'h0000_0010, 32'hFFFF_FFFC);
        chk(spec_ok_o == 1'b0, "R8 zero base carry fails", {31'd0, spec_ok_o}, 32'd0);
    endtask

    task automatic t_all_ones;
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk(spec_ok_o == 1'b0, "R4 all ones flag", {31'd0, spec_ok_o}, 32'd0);
        chk(true_addr_o == 32'hFFFF_FFFE, "R1 all ones sum", true_addr_o, 32'hFFFF_FFFE);
    endtask

    task automatic t_latency;
        apply(32'h0000_4000, 32'h0000_0004);
        @(negedge clk);
        base_i = 32'h0000_8000;
        imm_i  = 32'h0000_0020;
        #1;
        chk(true_addr_o == 32'h0000_4004, "R9 holds before edge", true_addr_o, 32'h0000_4004);
        @(posedge clk);
        #1;
        chk(true_addr_o == 32'h0000_8020, "R9 updates after edge", true_addr_o, 32'h0000_8020);
    endtask

    task automatic t_sweep;
        logic [31:0] lf = 32'hACE1_2345;
        for (int k = 0; k < 200; k++) begin
            logic [31:0] b;
            logic [31:0] i;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            b = lf & ((k % 3 == 0) ? 32'h0000_0FFF : 32'hFFFF_FFFF);
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            i = (k % 2 == 0) ? {{20{lf[11]}}, lf[11:0]} : {27'd0, lf[4:0]};
            full_check(b, i, "sweep");
        end
    endtask

    initial begin
        fork
            begin
                #400000;
                if (!done) begin
                    n_run++;
                    n_fail++;
                    $display("FAIL watchdog actual=hung expected=done");
                    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                    $finish;
                end
            end
        join_none
        t_reset();
        t_small_imm();
        t_carry_edge();
        t_overlap();
        t_negative();
        t_all_ones();
        t_latency();
        t_sweep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule